// File: doc/BRIEF.md
# Write-Hit Counting Test Peripheral

This block is a small bus target used to exercise a host's write path. It presents two byte-wide target windows, a 4096-byte memory window and a 256-byte I/O window. Both windows share one active-test register. Writing a small number to byte 0 of a window picks one of that window's three tests, or clears the selection when the number is out of range. While a test is active, every write that lands on that test's trigger address can raise the test's 32-bit hit counter. Whether it does depends on the test's kind: plain and wildcard tests count any such write, and data-match tests count only a single-byte write of 0xFA.

Software watches progress by reading a per-test header image one byte at a time. The image holds the test number, the access width, the trigger offset, the expected data byte, the live hit count and an ASCII name. Reads return one cycle after they are accepted. The memory window has priority: when both windows present a request in the same cycle, the I/O window is held off. This keeps the peripheral at one access per cycle.

Top module: `hitdev_top`

## Requirements
- R1: After reset no test is active, and a read of any address returns 0.
- R2: A write of value v < 3 to address 0 of a window activates test number w*3+v, with memory window w=0 and I/O window w=1. Header byte 0 then reads back that number.
- R3: A write of value 3 or more to address 0 leaves no test active. Afterwards every read returns 0.
- R4: Activating a test sets its hit count to zero. The count is readable little-endian at header bytes 12..15.
- R5: Header bytes 4..7 hold the trigger offset, little-endian. The offset is 2048+n for memory tests n=0..2 and 128+n for I/O tests n=3..5.
- R6: Tests with number mod 3 equal to 0 (plain) or 1 (wildcard) count every write to the trigger offset, whatever the data and size.
- R7: Tests with number mod 3 equal to 2 (data-match) count a trigger write only when the data is 0xFA and the size code is 0. Size code c means 2^c bytes.
- R8: Writes to any address other than 0 and the active trigger offset change no count.
- R9: Header byte 1 reads 1. Byte 8 reads 0xFA for data-match tests and 0xCE for the others. Bytes 2, 3, 9, 10 and 11 read 0.
- R10: From byte 16 the header holds the name "<mmio|portio>-<no|wildcard|datamatch>-eventfd", followed by a NUL.
- R11: A read returns the header byte only when address + 2^size is less than the header length, which is 17 + the name length. Otherwise it returns 0.
- R12: mem_ready is always 1. io_ready is 0 in any cycle in which mem_valid is 1.
- R13: An accepted read raises the window's rvalid, with its data, in the next cycle. Writes raise no rvalid.
- R14: A trigger write counts on whichever window carries it. For example, an I/O test's offset written through the memory window counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Memory window request |
| mem_ready | output | 1 | Memory window accept |
| mem_addr | input | MEM_AW | Memory window byte address |
| mem_we | input | 1 | Memory window write flag |
| mem_wdata | input | 8 | Memory window write byte |
| mem_size | input | 2 | Memory window access size code (2^code bytes) |
| mem_rvalid | output | 1 | Memory window read response valid |
| mem_rdata | output | 8 | Memory window read byte |
| io_valid | input | 1 | I/O window request |
| io_ready | output | 1 | I/O window accept |
| io_addr | input | IO_AW | I/O window byte address |
| io_we | input | 1 | I/O window write flag |
| io_wdata | input | 8 | I/O window write byte |
| io_size | input | 2 | I/O window access size code |
| io_rvalid | output | 1 | I/O window read response valid |
| io_rdata | output | 8 | I/O window read byte |

## Verification
The bench attacks the edges of the header image: the last byte of each name, and reads whose width pushes them past the end. A bounds check that is off by one would leak a byte or blank the final character. It writes the data-match trigger with the right byte at a wider size, and with a wrong byte. A design that ignored the size or the data would count both. It reselects a test that already has hits, to show the clear on activation, and writes an I/O test's trigger through the memory window. A decoder keyed to the window would miss that hit. Requests on both windows in the same cycle show the I/O window being held off.

// File: rtl/hitdev_pkg.sv
package hitdev_pkg;

    localparam int KINDS   = 3;
    localparam int WINDOWS = 2;
    localparam int TESTS   = KINDS * WINDOWS;
    localparam int IDX_W   = $clog2(TESTS);
    localparam int HDR_FIX = 16;

    localparam int MEM_TRIG_BASE = 2048;
    localparam int IO_TRIG_BASE  = 128;

    localparam logic [7:0] BYTE_MATCH = 8'hFA;
    localparam logic [7:0] BYTE_NONE  = 8'hCE;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_ANY   = 2'd1,
        KIND_MATCH = 2'd2
    } kind_e;

    localparam logic [8*5-1:0]  PFX_MEM = "mmio-";
    localparam logic [8*7-1:0]  PFX_IO  = "portio-";
    localparam logic [8*10-1:0] SFX_K0  = "no-eventfd";
    localparam logic [8*16-1:0] SFX_K1  = "wildcard-eventfd";
    localparam logic [8*17-1:0] SFX_K2  = "datamatch-eventfd";

    typedef struct packed {
        logic             act_valid;
        logic [IDX_W-1:0] act_idx;
        logic             mem_rvalid;
        logic             io_rvalid;
        logic [7:0]       mem_rdata;
        logic [7:0]       io_rdata;
    } state_t;

    function automatic kind_e kind_of(input logic [IDX_W-1:0] t);
        return kind_e'(2'(int'(t) % KINDS));
    endfunction

    function automatic bit is_io(input logic [IDX_W-1:0] t);
        return int'(t) >= KINDS;
    endfunction

    function automatic logic [15:0] trig_of(input logic [IDX_W-1:0] t);
        return is_io(t) ? 16'(IO_TRIG_BASE + int'(t)) : 16'(MEM_TRIG_BASE + int'(t));
    endfunction

    function automatic int pfx_len(input logic [IDX_W-1:0] t);
        return is_io(t) ? 7 : 5;
    endfunction

    function automatic int sfx_len(input logic [IDX_W-1:0] t);
        case (kind_of(t))
            KIND_PLAIN: return 10;
            KIND_ANY:   return 16;
            default:    return 17;
        endcase
    endfunction

    function automatic int hdr_len(input logic [IDX_W-1:0] t);
        return HDR_FIX + pfx_len(t) + sfx_len(t) + 1;
    endfunction

    // Character at position pos of the test's name; 0 past its end.
    function automatic logic [7:0] name_char(input logic [IDX_W-1:0] t, input int pos);
        int pl;
        int sl;
        int j;
        pl = pfx_len(t);
        sl = sfx_len(t);
        if (pos < 0) return 8'h00;
        if (pos < pl) begin
            if (is_io(t)) return PFX_IO[8*(pl-1-pos) +: 8];
            return PFX_MEM[8*(pl-1-pos) +: 8];
        end
        j = pos - pl;
        if (j >= sl) return 8'h00;
        case (kind_of(t))
            KIND_PLAIN: return SFX_K0[8*(sl-1-j) +: 8];
            KIND_ANY:   return SFX_K1[8*(sl-1-j) +: 8];
            default:    return SFX_K2[8*(sl-1-j) +: 8];
        endcase
    endfunction

endpackage

// File: rtl/hitdev_dec.sv
module hitdev_dec
    import hitdev_pkg::*;
#(
    parameter int AW  = 12,
    parameter int WIN = 0
) (
    input  logic             acc,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    input  logic [1:0]       size,
    input  logic             act_valid,
    input  logic [IDX_W-1:0] act_idx,
    output logic             sel,
    output logic             sel_ok,
    output logic [IDX_W-1:0] sel_idx,
    output logic             hit
);
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(WIN * KINDS);

    logic wr;
    logic at_zero;
    logic at_trig;
    logic data_ok;

    always_comb begin
        wr      = acc && we;
        at_zero = (addr == '0);
        at_trig = (32'(addr) == 32'(trig_of(act_idx)));
        data_ok = (kind_of(act_idx) != KIND_MATCH) ||
                  ((wdata == BYTE_MATCH) && (size == 2'd0));
        sel     = wr && at_zero;
        sel_ok  = (int'(wdata) < KINDS);
        sel_idx = BASE_IDX + IDX_W'(wdata[1:0]);
        hit     = wr && !at_zero && act_valid && at_trig && data_ok;
    end
endmodule

// File: rtl/hitdev_cnt.sv
module hitdev_cnt
    import hitdev_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             inc,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count
);
    logic [CNT_W-1:0] cnt_d [TESTS];
    logic [CNT_W-1:0] cnt_q [TESTS];

    for (genvar g = 0; g < TESTS; g++) begin : g_slot
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (clr && (clr_idx == IDX_W'(g))) begin
                cnt_d[g] = '0;
            end else if (inc && (inc_idx == IDX_W'(g))) begin
                cnt_d[g] = cnt_q[g] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < TESTS; i++) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end
    end

    always_comb begin
        rd_count = '0;
        for (int i = 0; i < TESTS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_count = cnt_q[i];
        end
    end
endmodule

// File: rtl/hitdev_hdr.sv
module hitdev_hdr
    import hitdev_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int AW    = 12
) (
    input  logic             act_valid,
    input  logic [IDX_W-1:0] act_idx,
    input  logic [CNT_W-1:0] count,
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       size,
    output logic [7:0]       rbyte
);
    logic [31:0] cnt32;
    logic [15:0] trig;
    logic        in_range;
    int          end_pos;

    always_comb begin
        cnt32    = 32'(count);
        trig     = trig_of(act_idx);
        end_pos  = int'(addr) + (1 << size);
        in_range = act_valid && (end_pos < hdr_len(act_idx));
        rbyte    = 8'h00;
        if (in_range) begin
            case (int'(addr))
                0:  rbyte = 8'(act_idx);
                1:  rbyte = 8'd1;
                4:  rbyte = trig[7:0];
                5:  rbyte = trig[15:8];
                8:  rbyte = (kind_of(act_idx) == KIND_MATCH) ? BYTE_MATCH : BYTE_NONE;
                12: rbyte = cnt32[7:0];
                13: rbyte = cnt32[15:8];
                14: rbyte = cnt32[23:16];
                15: rbyte = cnt32[31:24];
                default: begin
                    if (int'(addr) >= HDR_FIX) rbyte = name_char(act_idx, int'(addr) - HDR_FIX);
                end
            endcase
        end
    end
endmodule

// File: rtl/hitdev_top.sv
module hitdev_top
    import hitdev_pkg::*;
#(
    parameter int MEM_AW = 12,
    parameter int IO_AW  = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_we,
    input  logic [7:0]        mem_wdata,
    input  logic [1:0]        mem_size,
    output logic              mem_rvalid,
    output logic [7:0]        mem_rdata,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_we,
    input  logic [7:0]        io_wdata,
    input  logic [1:0]        io_size,
    output logic              io_rvalid,
    output logic [7:0]        io_rdata
);
    localparam int HAW = (MEM_AW > IO_AW) ? MEM_AW : IO_AW;

    state_t st_d, st_q;

    logic             mem_acc, io_acc;
    logic             m_sel, m_ok, m_hit, i_sel, i_ok, i_hit;
    logic [IDX_W-1:0] m_idx, i_idx;
    logic             sel_any, sel_take;
    logic [IDX_W-1:0] sel_pick;
    logic [HAW-1:0]   rd_addr;
    logic [1:0]       rd_size;
    logic [CNT_W-1:0] cur_count;
    logic [7:0]       hdr_byte;

    assign mem_ready = 1'b1;
    assign io_ready  = !mem_valid;
    assign mem_acc   = mem_valid;
    assign io_acc    = io_valid && !mem_valid;

    hitdev_dec #(.AW(MEM_AW), .WIN(0)) u_dec_mem (
        .acc(mem_acc), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .size(mem_size),
        .act_valid(st_q.act_valid), .act_idx(st_q.act_idx),
        .sel(m_sel), .sel_ok(m_ok), .sel_idx(m_idx), .hit(m_hit)
    );

    hitdev_dec #(.AW(IO_AW), .WIN(1)) u_dec_io (
        .acc(io_acc), .we(io_we), .addr(io_addr), .wdata(io_wdata), .size(io_size),
        .act_valid(st_q.act_valid), .act_idx(st_q.act_idx),
        .sel(i_sel), .sel_ok(i_ok), .sel_idx(i_idx), .hit(i_hit)
    );

    assign sel_any  = m_sel || i_sel;
    assign sel_take = m_sel ? m_ok : (i_sel && i_ok);
    assign sel_pick = m_sel ? m_idx : i_idx;

    hitdev_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(sel_take), .clr_idx(sel_pick),
        .inc(m_hit || i_hit), .inc_idx(st_q.act_idx),
        .rd_idx(st_q.act_idx), .rd_count(cur_count)
    );

    assign rd_addr = mem_acc ? HAW'(mem_addr) : HAW'(io_addr);
    assign rd_size = mem_acc ? mem_size : io_size;

    hitdev_hdr #(.CNT_W(CNT_W), .AW(HAW)) u_hdr (
        .act_valid(st_q.act_valid), .act_idx(st_q.act_idx), .count(cur_count),
        .addr(rd_addr), .size(rd_size), .rbyte(hdr_byte)
    );

    always_comb begin
        st_d            = st_q;
        st_d.mem_rvalid = mem_acc && !mem_we;
        st_d.io_rvalid  = io_acc && !io_we;
        st_d.mem_rdata  = (mem_acc && !mem_we) ? hdr_byte : 8'h00;
        st_d.io_rdata   = (io_acc && !io_we) ? hdr_byte : 8'h00;
        if (sel_any) begin
            st_d.act_valid = sel_take;
            st_d.act_idx   = sel_take ? sel_pick : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rvalid = st_q.mem_rvalid;
    assign mem_rdata  = st_q.mem_rdata;
    assign io_rvalid  = st_q.io_rvalid;
    assign io_rdata   = st_q.io_rdata;
endmodule

// File: rtl/hitdev_chk.sv
module hitdev_chk
    import hitdev_pkg::*;
#(
    parameter int MEM_AW = 12,
    parameter int IO_AW  = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [7:0]        mem_rdata,
    input logic              io_valid,
    input logic              io_ready,
    input logic              io_we,
    input logic [IO_AW-1:0]  io_addr,
    input logic [7:0]        io_wdata,
    input logic              act_valid,
    input logic [IDX_W-1:0]  act_idx,
    input logic              sel_take,
    input logic [CNT_W-1:0]  cur_count
);
    a_r12_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !io_ready);

    a_r13_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |=> mem_rvalid);

    a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && !act_valid) |=> (mem_rdata == 8'h00));

    a_r4_clear_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        sel_take |=> (act_valid && (cur_count == '0)));

    a_r11_far_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && (int'(mem_addr) >= 64)) |=> (mem_rdata == 8'h00));

    a_r2_io_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready && io_we && (io_addr == '0) && (int'(io_wdata) < KINDS))
            |=> (int'(act_idx) >= KINDS));

    a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !sel_take && !(mem_valid && mem_we && mem_addr == '0)
                   && !(io_valid && io_ready && io_we && io_addr == '0))
            |=> ((cur_count == $past(cur_count)) || (cur_count == $past(cur_count) + CNT_W'(1))));
endmodule

bind hitdev_top hitdev_chk #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata),
    .act_valid(st_q.act_valid), .act_idx(st_q.act_idx),
    .sel_take(sel_take), .cur_count(cur_count)
);

// File: tb/sim_hitdev_top.sv
module sim_hitdev_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mem_valid, mem_ready, mem_we, mem_rvalid;
    logic [11:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [1:0] mem_size;
    logic       io_valid, io_ready, io_we, io_rvalid;
    logic [7:0] io_addr, io_wdata, io_rdata;
    logic [1:0] io_size;

    always #10 clk = ~clk;

    hitdev_top u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr), .io_we(io_we),
        .io_wdata(io_wdata), .io_size(io_size), .io_rvalid(io_rvalid), .io_rdata(io_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m_act = 0;
    int m_idx = 0;
    logic [31:0] m_cnt [6];
    string names [6] = '{"mmio-no-eventfd", "mmio-wildcard-eventfd", "mmio-datamatch-eventfd",
                         "portio-no-eventfd", "portio-wildcard-eventfd", "portio-datamatch-eventfd"};

    function automatic int trig(int t);
        return (t < 3) ? 2048 + t : 128 + t;
    endfunction

    function automatic logic [7:0] hbyte(int t, int a);
        logic [31:0] o;
        o = trig(t);
        case (a)
            0: return 8'(t);
            1: return 8'd1;
            4: return o[7:0];
            5: return o[15:8];
            6, 7: return 8'd0;
            8: return (t % 3 == 2) ? 8'hFA : 8'hCE;
            12: return m_cnt[t][7:0];
            13: return m_cnt[t][15:8];
            14: return m_cnt[t][23:16];
            15: return m_cnt[t][31:24];
            default: begin
                if (a >= 16 && (a - 16) < names[t].len()) return names[t][a-16];
                return 8'd0;
            end
        endcase
    endfunction

    function automatic logic [7:0] exp_read(int a, int sz);
        if (!m_act) return 8'd0;
        if (a + (1 << sz) >= 17 + names[m_idx].len()) return 8'd0;
        return hbyte(m_idx, a);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; one access per call.
    task automatic acc(bit win, int addr, bit we, logic [7:0] d, int sz, string req);
        logic [7:0] expv;
        int a;
        a = win ? (addr & 255) : (addr & 4095);
        expv = exp_read(a, sz);
        if (!win) begin
            mem_valid = 1; mem_addr = 12'(a); mem_we = we; mem_wdata = d; mem_size = 2'(sz);
        end else begin
            io_valid = 1; io_addr = 8'(a); io_we = we; io_wdata = d; io_size = 2'(sz);
        end
        @(negedge clk);
        mem_valid = 0; io_valid = 0;
        if (we) begin
            check("R13", {31'd0, win ? io_rvalid : mem_rvalid}, 32'd0);
            if (a == 0) begin
                m_act = (d < 3);
                if (d < 3) begin
                    m_idx = (win ? 3 : 0) + int'(d);
                    m_cnt[m_idx] = 0;
                end
            end else if (m_act && a == trig(m_idx) &&
                         ((m_idx % 3 != 2) || (d == 8'hFA && sz == 0))) begin
                m_cnt[m_idx] = m_cnt[m_idx] + 1;
            end
        end else begin
            check("R13", {31'd0, win ? io_rvalid : mem_rvalid}, 32'd1);
            check(req, {24'd0, win ? io_rdata : mem_rdata}, {24'd0, expv});
        end
    endtask

    task automatic rd_count(bit win, string req);
        for (int k = 12; k < 16; k++) acc(win, k, 0, 8'h00, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 6; i++) m_cnt[i] = 0;
        rst_n = 0; mem_valid = 0; io_valid = 0;
        mem_addr = 0; mem_we = 0; mem_wdata = 0; mem_size = 0;
        io_addr = 0; io_we = 0; io_wdata = 0; io_size = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: nothing active after reset
        acc(0, 0, 0, 0, 0, "R1");
        acc(1, 12, 0, 0, 0, "R1");
        // R12: arbitration
        check("R12", {31'd0, mem_ready}, 32'd1);
        check("R12", {31'd0, io_ready}, 32'd1);
        mem_valid = 1; io_valid = 1; mem_we = 0; io_we = 0; mem_addr = 12'd40; io_addr = 8'd40;
        #1 check("R12", {31'd0, io_ready}, 32'd0);
        @(negedge clk); mem_valid = 0; io_valid = 0;
        check("R12", {31'd0, io_rvalid}, 32'd0);
        @(negedge clk);

        // R2, R5, R9, R10 on memory wildcard test
        acc(0, 0, 1, 8'd1, 0, "R2");
        acc(0, 0, 0, 0, 0, "R2");
        for (int k = 4; k < 8; k++) acc(0, k, 0, 0, 0, "R5");
        for (int k = 1; k < 12; k++) acc(0, k, 0, 0, 0, "R9");
        for (int k = 16; k < 40; k++) acc(0, k, 0, 0, 0, "R10");
        // R6: any data, any size
        acc(0, 2049, 1, 8'h12, 2, "R6");
        acc(0, 2049, 1, 8'hCE, 0, "R6");
        // R8: neighbouring addresses
        acc(0, 2050, 1, 8'hFA, 0, "R8");
        acc(0, 2048, 1, 8'hFA, 0, "R8");
        rd_count(0, "R6");
        // R4: reselect clears
        acc(0, 0, 1, 8'd1, 0, "R4");
        rd_count(0, "R4");

        // R7: I/O data-match test, trigger 133
        acc(1, 0, 1, 8'd2, 0, "R2");
        acc(1, 0, 0, 0, 0, "R2");
        acc(1, 133, 1, 8'hFA, 0, "R7");
        acc(1, 133, 1, 8'hFA, 1, "R7");
        acc(1, 133, 1, 8'h11, 0, "R7");
        rd_count(1, "R7");
        for (int k = 4; k < 9; k++) acc(1, k, 0, 0, 0, "R5");
        // R11: boundary reads on len 41
        acc(1, 39, 0, 0, 0, "R11");
        acc(1, 40, 0, 0, 0, "R11");
        acc(1, 38, 0, 0, 1, "R11");
        acc(1, 39, 0, 0, 1, "R11");
        acc(1, 36, 0, 0, 2, "R11");
        acc(1, 37, 0, 0, 2, "R11");

        // R14: I/O wildcard trigger 132 hit through memory window
        acc(1, 0, 1, 8'd1, 0, "R2");
        acc(0, 132, 1, 8'h00, 0, "R14");
        acc(1, 132, 1, 8'h55, 1, "R14");
        rd_count(0, "R14");

        // R11 on memory plain test, len 32
        acc(0, 0, 1, 8'd0, 0, "R2");
        acc(0, 30, 0, 0, 0, "R11");
        acc(0, 31, 0, 0, 0, "R11");
        acc(0, 30, 0, 0, 1, "R11");
        acc(0, 28, 0, 0, 2, "R11");
        acc(0, 2048, 1, 8'h33, 1, "R6");
        rd_count(0, "R6");

        // R3: out-of-range select
        acc(0, 0, 1, 8'd3, 0, "R3");
        acc(0, 0, 0, 0, 0, "R3");
        acc(0, 12, 0, 0, 0, "R3");
        acc(1, 0, 1, 8'd200, 0, "R3");
        acc(1, 16, 0, 0, 0, "R3");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            bit w;
            int pick, a, sz, t;
            logic [7:0] d;
            string tag;
            w = $urandom_range(0, 1);
            pick = $urandom_range(0, 9);
            t = $urandom_range(0, 5);
            sz = $urandom_range(0, 2);
            case ($urandom_range(0, 3))
                0: d = 8'hFA;
                1: d = 8'hCE;
                2: d = 8'($urandom_range(0, 5));
                default: d = 8'($urandom);
            endcase
            if (pick == 0) begin
                a = 0; d = 8'($urandom_range(0, 4));
                acc(w, a, 1, d, 0, "R2");
            end else if (pick < 5) begin
                acc(w, trig(t), 1, d, sz, "R7");
            end else begin
                a = (pick == 9) ? $urandom_range(0, 4095) : $urandom_range(0, 44);
                if (a < 4) tag = "R2";
                else if (a < 8) tag = "R5";
                else if (a < 12) tag = "R9";
                else if (a < 16) tag = "R6";
                else tag = "R10";
                acc(w, a, 0, 0, sz, tag);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule